// File: doc/BRIEF.md
# Streaming ROM Module Signature Checker

This block verifies a read-only memory module while its contents stream past, one byte per accepted cycle. A start strobe arms it and captures the identifier the caller expects to find. Every accepted byte is folded into a 16-bit cyclic redundancy register. The last two bytes of a module are signature bytes chosen so that a good module leaves the register at zero. The byte three positions before the end of the module carries the module's own identifier, and the block latches it as it passes.

After the final byte the block raises `done` and reports two verdicts: one for the CRC and one for the identity. It also reports the expected identifier and the identifier it actually found. An error display can therefore show a fault as a pair, for example expected 0x18 against found 0x07. The results stay frozen until the next start. Addressing the memory, choosing the module and driving any display are left to the surrounding logic.

Top module: `rom_sig_checker`

## Requirements
- R1: After reset, `busy`, `done`, `crc_ok`, `id_ok` and `pass` are 0, `read_id` and `expected_id` are 0x00, and `residue` is 0xFFFF.
- R2: A cycle with `start` high loads `residue` with 0xFFFF, clears the byte count, drops `done`, raises `busy`, clears `crc_ok`, `id_ok` and `read_id`, and captures `exp_id` into `expected_id`, all at the next clock edge.
- R3: While busy, each cycle with `in_valid` high and `start` low accepts one byte and updates `residue` by the polynomial 0x1021. The byte is taken most significant bit first, with no reflection and no final XOR. Starting from 0xFFFF, the bytes 0x01, 0x02 and 0x03 give 0xF1D1, 0x0E7C and 0xADAD in turn.
- R4: `done` rises at the edge that accepts the 6144th byte (0x1800) after a start, and not before. Cycles with `in_valid` low do not count as bytes.
- R5: `crc_ok` is 1 exactly when `residue` is 0x0000 after the 6144th byte.
- R6: The byte at offset 6141 of the module, counting from 0, is latched and shown on `read_id`.
- R7: `id_ok` is 1 exactly when the latched identifier equals `expected_id`.
- R8: `pass` is 1 exactly when `done`, `crc_ok` and `id_ok` are all 1.
- R9: Bytes offered while not busy, or in the same cycle as `start`, are ignored: `residue`, `done` and the verdicts do not change.
- R10: From the rise of `done` until the next start, `done`, `crc_ok`, `id_ok`, `read_id` and `residue` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Arms a new module check |
| exp_id | input | 8 | Expected identifier, captured on start |
| in_valid | input | 1 | Byte on `in_byte` is offered |
| in_byte | input | 8 | Module byte |
| busy | output | 1 | A module is being checked |
| done | output | 1 | All bytes of the module were accepted |
| residue | output | 16 | CRC register value |
| expected_id | output | 8 | Identifier captured at start |
| read_id | output | 8 | Identifier found in the module |
| crc_ok | output | 1 | CRC residue was zero |
| id_ok | output | 1 | Found identifier equals expected one |
| pass | output | 1 | Both verdicts good while done |

## Verification
Each result appears one clock edge after the cycle that causes it. `residue` follows an accepted byte at the next edge. `busy`, `expected_id` and the reload follow `start` at the next edge. `done` and both verdicts appear at the edge that accepts the final byte. The bench drives inputs on the falling edge and samples one falling edge later, so every check falls exactly one edge after its stimulus. The `done`-low check is taken just before the final byte is offered, and the hold checks sample several idle cycles after `done` has risen.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_RUN  = 2'd1,
      PH_DONE = 2'd2
   } rsc_phase_e;

   typedef struct packed {
      logic crc_ok;
      logic id_ok;
   } rsc_verdict_t;

endpackage

// File: rtl/rsc_crc_unit.sv
module rsc_crc_unit #(
   parameter int          CRC_W  = 16,
   parameter int          DATA_W = 8,
   parameter logic [15:0] POLY   = 16'h1021,
   parameter logic [15:0] SEED   = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              en,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc,
   output logic [CRC_W-1:0]  crc_next
);

   localparam logic [CRC_W-1:0] POLY_W = CRC_W'(POLY);
   localparam logic [CRC_W-1:0] SEED_W = CRC_W'(SEED);

   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = crc;

   // one shift-and-reduce step per data bit, most significant bit first
   for (genvar k = 0; k < DATA_W; k++) begin : g_bit
      logic fb;
      assign fb = stage[k][CRC_W-1] ^ data[DATA_W-1-k];
      assign stage[k+1] = {stage[k][CRC_W-2:0], 1'b0} ^ (fb ? POLY_W : '0);
   end

   assign crc_next = stage[DATA_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    crc <= SEED_W;
      else if (load) crc <= SEED_W;
      else if (en)   crc <= crc_next;
   end

endmodule

// File: rtl/rsc_byte_tracker.sv
module rsc_byte_tracker
   import rsc_pkg::*;
#(
   parameter int MOD_BYTES = 6144,
   parameter int ID_POS    = 6141,
   localparam int CNT_W    = $clog2(MOD_BYTES)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic in_valid,
   output logic accept,
   output logic id_hit,
   output logic last_hit,
   output logic busy,
   output logic done
);

   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(MOD_BYTES - 1);
   localparam logic [CNT_W-1:0] ID_IDX   = CNT_W'(ID_POS);

   rsc_phase_e       phase;
   logic [CNT_W-1:0] cnt;

   assign busy     = (phase == PH_RUN);
   assign done     = (phase == PH_DONE);
   assign accept   = busy && in_valid && !start;
   assign id_hit   = accept && (cnt == ID_IDX);
   assign last_hit = accept && (cnt == LAST_IDX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         cnt   <= '0;
      end else if (start) begin
         phase <= PH_RUN;
         cnt   <= '0;
      end else if (accept) begin
         if (last_hit) begin
            phase <= PH_DONE;
            cnt   <= '0;
         end else begin
            cnt   <= cnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/rsc_verdict.sv
module rsc_verdict
   import rsc_pkg::*;
#(
   parameter int ID_W  = 8,
   parameter int CRC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [ID_W-1:0]  exp_id,
   input  logic [ID_W-1:0]  in_id,
   input  logic             id_hit,
   input  logic             last_hit,
   input  logic [CRC_W-1:0] crc_next,
   output logic [ID_W-1:0]  expected_id,
   output logic [ID_W-1:0]  read_id,
   output rsc_verdict_t     verdict
);

   logic [ID_W-1:0] id_now;

   // the identifier may sit on the final byte in small configurations
   assign id_now = id_hit ? in_id : read_id;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         expected_id <= '0;
         read_id     <= '0;
         verdict     <= '0;
      end else if (start) begin
         expected_id <= exp_id;
         read_id     <= '0;
         verdict     <= '0;
      end else begin
         if (id_hit) read_id <= in_id;
         if (last_hit) begin
            verdict.crc_ok <= (crc_next == '0);
            verdict.id_ok  <= (id_now == expected_id);
         end
      end
   end

endmodule

// File: rtl/rom_sig_checker.sv
module rom_sig_checker
   import rsc_pkg::*;
#(
   parameter int          MOD_BYTES   = 6144,
   parameter int          ID_FROM_END = 3,
   parameter int          DATA_W      = 8,
   parameter int          CRC_W       = 16,
   parameter logic [15:0] POLY        = 16'h1021,
   parameter logic [15:0] SEED        = 16'hFFFF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] exp_id,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_byte,
   output logic              busy,
   output logic              done,
   output logic [CRC_W-1:0]  residue,
   output logic [DATA_W-1:0] expected_id,
   output logic [DATA_W-1:0] read_id,
   output logic              crc_ok,
   output logic              id_ok,
   output logic              pass
);

   localparam int ID_POS = MOD_BYTES - ID_FROM_END;

   if (MOD_BYTES < 4) begin : g_bad_len
      $error("rom_sig_checker: MOD_BYTES too small");
   end
   if (ID_FROM_END < 1 || ID_FROM_END > MOD_BYTES) begin : g_bad_idpos
      $error("rom_sig_checker: ID_FROM_END out of range");
   end
   if (CRC_W < 2 || CRC_W > 16) begin : g_bad_crcw
      $error("rom_sig_checker: CRC_W must be 2..16");
   end

   logic               accept, id_hit, last_hit;
   logic [CRC_W-1:0]   crc_next;
   rsc_verdict_t       verdict;

   rsc_byte_tracker #(
      .MOD_BYTES (MOD_BYTES),
      .ID_POS    (ID_POS)
   ) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .in_valid (in_valid),
      .accept   (accept),
      .id_hit   (id_hit),
      .last_hit (last_hit),
      .busy     (busy),
      .done     (done)
   );

   rsc_crc_unit #(
      .CRC_W  (CRC_W),
      .DATA_W (DATA_W),
      .POLY   (POLY),
      .SEED   (SEED)
   ) u_crc (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start),
      .en       (accept),
      .data     (in_byte),
      .crc      (residue),
      .crc_next (crc_next)
   );

   rsc_verdict #(
      .ID_W  (DATA_W),
      .CRC_W (CRC_W)
   ) u_verdict (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .exp_id      (exp_id),
      .in_id       (in_byte),
      .id_hit      (id_hit),
      .last_hit    (last_hit),
      .crc_next    (crc_next),
      .expected_id (expected_id),
      .read_id     (read_id),
      .verdict     (verdict)
   );

   assign crc_ok = verdict.crc_ok;
   assign id_ok  = verdict.id_ok;
   assign pass   = done && verdict.crc_ok && verdict.id_ok;

endmodule

// File: rtl/rsc_checker.sv
module rsc_checker #(
   parameter int MOD_BYTES = 6144,
   parameter int DATA_W    = 8,
   parameter int CRC_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              in_valid,
   input logic              busy,
   input logic              done,
   input logic [CRC_W-1:0]  residue,
   input logic [DATA_W-1:0] read_id,
   input logic              crc_ok,
   input logic              id_ok,
   input logic              pass
);

   localparam int CW = $clog2(MOD_BYTES) + 2;

   logic [CW-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           seen <= '0;
      else if (start)                       seen <= '0;
      else if (busy && in_valid)            seen <= seen + 1'b1;
   end

   p_start_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !done && residue == {CRC_W{1'b1}}));

   p_count_at_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (seen == CW'(MOD_BYTES)));

   p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_crc_verdict_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (crc_ok == (residue == '0)));

   p_pass_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> (done && crc_ok && id_ok));

   p_idle_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(residue));

   p_results_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (done && $stable(crc_ok) && $stable(id_ok) && $stable(read_id)));

endmodule

bind rom_sig_checker rsc_checker #(
   .MOD_BYTES (MOD_BYTES),
   .DATA_W    (DATA_W),
   .CRC_W     (CRC_W)
) u_rsc_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .in_valid (in_valid),
   .busy     (busy),
   .done     (done),
   .residue  (residue),
   .read_id  (read_id),
   .crc_ok   (crc_ok),
   .id_ok    (id_ok),
   .pass     (pass)
);

// File: tb/tb_rom_sig_checker.sv
module tb_rom_sig_checker;

   localparam int CLK_PERIOD = 10;
   localparam int NBYTES     = 6144;
   localparam int ID_AT      = NBYTES - 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  exp_id = 8'h00;
   logic        in_valid = 1'b0;
   logic [7:0]  in_byte = 8'h00;
   logic        busy, done, crc_ok, id_ok, pass;
   logic [15:0] residue;
   logic [7:0]  expected_id, read_id;

   int total = 0;
   int bad   = 0;
   bit ended = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rom_sig_checker dut (
      .clk(clk), .rst_n(rst_n), .start(start), .exp_id(exp_id),
      .in_valid(in_valid), .in_byte(in_byte), .busy(busy), .done(done),
      .residue(residue), .expected_id(expected_id), .read_id(read_id),
      .crc_ok(crc_ok), .id_ok(id_ok), .pass(pass)
   );

   function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c;
      for (int i = 7; i >= 0; i--) begin
         if (r[15] ^ b[i]) r = (r << 1) ^ 16'h1021;
         else              r = r << 1;
      end
      return r;
   endfunction

   function automatic logic [7:0] pat(input int seed, input int i);
      return 8'((i * (seed * 2 + 1)) + (i >> 7) + seed);
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, expv);
      end
   endtask

   task automatic push(input logic [7:0] b);
      in_valid = 1'b1;
      in_byte  = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic do_start(input logic [7:0] e);
      start  = 1'b1;
      exp_id = e;
      @(negedge clk);
      start  = 1'b0;
   endtask

   // Streams one module: id byte at offset 6141, signature bytes appended.
   task automatic run_module(input int seed, input logic [7:0] id_b, input logic [7:0] e,
                             input bit corrupt, input int gap_every);
      logic [15:0] c;
      logic [7:0]  b;
      bit          exp_crc;
      c = 16'hFFFF;
      do_start(e);
      for (int i = 0; i < NBYTES - 2; i++) begin
         b = (i == ID_AT) ? id_b : pat(seed, i);
         c = ref_crc(c, b);
         push((corrupt && i == 77) ? (b ^ 8'h40) : b);
         if (gap_every > 0 && (i % gap_every) == 0) @(negedge clk);
      end
      push(c[15:8]);
      // R4: one byte short, done must still be low
      chk(done == 1'b0 && busy == 1'b1, "R4 done early", done, 0);
      push(c[7:0]);
      exp_crc = !corrupt;
      chk(done == 1'b1 && busy == 1'b0, "R4 done after last byte", done, 1);
      chk(crc_ok == exp_crc, "R5 crc_ok", crc_ok, exp_crc);
      if (!corrupt)
         chk(residue == 16'h0000, "R5 zero residue", residue, 0);
      chk(read_id == id_b, "R6 read_id", read_id, id_b);
      chk(expected_id == e, "R7 expected_id", expected_id, e);
      chk(id_ok == (id_b == e), "R7 id_ok", id_ok, (id_b == e));
      chk(pass == (exp_crc && id_b == e), "R8 pass", pass, (exp_crc && id_b == e));
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!ended) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] r_hold;
      logic [7:0]  id_hold;
      logic        ok_hold;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0 && done == 0, "R1 busy/done", {busy, done}, 0);
      chk(crc_ok == 0 && id_ok == 0 && pass == 0, "R1 verdicts", {crc_ok, id_ok, pass}, 0);
      chk(read_id == 0 && expected_id == 0, "R1 ids", {read_id, expected_id}, 0);
      chk(residue == 16'hFFFF, "R1 residue", residue, 16'hFFFF);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: bytes offered before any start are ignored
      push(8'h5A);
      push(8'hA5);
      chk(residue == 16'hFFFF && !busy && !done, "R9 idle bytes", residue, 16'hFFFF);

      // R2 start
      do_start(8'h18);
      chk(busy == 1 && done == 0 && residue == 16'hFFFF, "R2 start", {busy, done, residue}, {2'b10, 16'hFFFF});
      chk(expected_id == 8'h18, "R2 expected capture", expected_id, 8'h18);

      // R3 test vectors
      push(8'h01);
      chk(residue == 16'hF1D1, "R3 after 0x01", residue, 16'hF1D1);
      in_valid = 1'b0; @(negedge clk);
      chk(residue == 16'hF1D1, "R3 invalid cycle holds", residue, 16'hF1D1);
      push(8'h02);
      chk(residue == 16'h0E7C, "R3 after 0x02", residue, 16'h0E7C);
      push(8'h03);
      chk(residue == 16'hADAD, "R3 after 0x03", residue, 16'hADAD);

      // R9: byte in the start cycle is ignored
      start = 1'b1; exp_id = 8'h18; in_valid = 1'b1; in_byte = 8'h01;
      @(negedge clk);
      start = 1'b0; in_valid = 1'b0;
      chk(residue == 16'hFFFF, "R9 byte with start ignored", residue, 16'hFFFF);

      // good module, gaps in the stream
      run_module(1, 8'h18, 8'h18, 1'b0, 5);

      // R10 / R9: idle bytes after done leave results alone
      r_hold = residue; id_hold = read_id; ok_hold = crc_ok;
      push(8'h33); push(8'hCC);
      repeat (3) @(negedge clk);
      chk(done && residue == r_hold, "R10 residue held", residue, r_hold);
      chk(read_id == id_hold && crc_ok == ok_hold && pass, "R10 verdicts held", read_id, id_hold);

      // R2: start clears the previous results
      do_start(8'h07);
      chk(!done && !crc_ok && !id_ok && !pass && read_id == 0, "R2 clear on start",
          {done, crc_ok, id_ok, pass, read_id}, 0);

      // identity mismatch: expected 0x18, module carries 0x07
      run_module(2, 8'h07, 8'h18, 1'b0, 0);
      // CRC corrupted, identity right
      run_module(3, 8'h42, 8'h42, 1'b1, 0);
      // sweep of identifiers and patterns
      for (int s = 0; s < 3; s++) begin
         run_module(4 + s, 8'(s * 85 + 1), 8'(s * 85 + 1), 1'b0, 0);
      end
      run_module(9, 8'hFF, 8'h00, 1'b0, 0);

      // R2: restart mid-module discards the partial module
      do_start(8'h11);
      for (int i = 0; i < 10; i++) push(8'(i));
      run_module(10, 8'h11, 8'h11, 1'b0, 0);

      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule